// File: doc/BRIEF.md
# Programmable Serial Clock Divider with Settle Flag

This block derives a serial flash clock from a faster base clock. Software programs it through one control word that carries a run enable, a read-only "settled" flag and an 8-bit divider. The serial clock runs at the base rate divided by twice the effective divider. Each level therefore lasts N base cycles, where N is the divider, or 1 when the divider is 0. A downstream shifter gets two one-cycle strobes that mark the rising and falling transitions of the serial clock, so it can launch and capture data without a clock-domain crossing.

Every write to the control word restarts the divided clock at its idle level and drops the settled flag. The flag comes back only after the clock has completed a fixed number of full periods at the new rate. Software polls the flag after reprogramming the rate, before it starts a transfer. The idle level follows a polarity input.

Top module: `sckdiv_top`

## Requirements
- R1: After reset, `sck` equals `cpol`, both strobes are 0, the divider and enable are 0, and a read returns 0.
- R2: While the enable bit (bit 0) is 0, `sck` holds the idle level `cpol` and no strobe fires.
- R3: The divider is bits 15:8. With divider N ≥ 1 and the clock enabled, the first transition of `sck` comes N base cycles after the write edge, and later ones follow every N cycles.
- R4: A divider of 0 behaves as 1, so `sck` toggles on every base cycle.
- R5: The idle level equals `cpol`. The first transition after a restart moves `sck` away from the idle level: it is a rise when `cpol` = 0 and a fall when `cpol` = 1.
- R6: `sck_rise` is high for exactly the one base cycle in which `sck` has just become 1. `sck_fall` is high for exactly the one cycle in which `sck` has just become 0. The two are never high together.
- R7: Every write restarts the divided clock. From the write edge onward, `sck` is at the idle level and the half-period count starts again from zero.
- R8: The stable flag (bit 1) clears on every write. It sets on the base edge of the fourth `sck` transition after the write, which is 4·N cycles later when the clock is enabled. While the clock is disabled, the flag stays 0.
- R9: A read strobe loads `reg_rdata` on the next edge with the enable (bit 0), the stable flag (bit 1) and the divider (bits 15:8). All other bits are 0. Without a read strobe, `reg_rdata` holds its value.
- R10: Write data outside bit 0 and bits 15:8 has no effect. Writing a 1 to bit 1 does not set the stable flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe for the control word |
| reg_rd | input | 1 | Read strobe for the control word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| cpol | input | 1 | Idle level of the serial clock |
| sck | output | 1 | Divided serial clock |
| sck_rise | output | 1 | One-cycle strobe on each rising transition of `sck` |
| sck_fall | output | 1 | One-cycle strobe on each falling transition of `sck` |

## Verification
A half-period counter that is off by one shows up at the ports within one serial clock period: a strobe lands a cycle early or late, so the cycle-by-cycle comparison of `sck` and the strobes catches it at once. A wrong phase after a restart makes the first transition go the wrong way in the first N cycles after the write. A wrong settle count or a missed clear only becomes visible through a read. For that reason the bench reads the flag in the cycle just before it should set and again in the cycle just after.

// File: rtl/sckdiv_pkg.sv
package sckdiv_pkg;
    localparam int unsigned REG_W   = 32;
    localparam int unsigned EN_POS  = 0;
    localparam int unsigned STB_POS = 1;
    localparam int unsigned DIV_LSB = 8;
    localparam int unsigned DIV_W   = 8;

    typedef logic [DIV_W-1:0] div_t;

    typedef struct packed {
        logic en;
        div_t div;
    } ctl_t;

    typedef struct packed {
        logic rise;
        logic fall;
    } strobe_t;

    // zero divider maps to the fastest legal rate
    function automatic div_t eff_div(input div_t d);
        return (d == '0) ? div_t'(1) : d;
    endfunction
endpackage

// File: rtl/sckdiv_regs.sv
module sckdiv_regs
    import sckdiv_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic             rd,
    input  logic [REG_W-1:0] wdata,
    input  logic             stable,
    output ctl_t             ctl,
    output logic [REG_W-1:0] rdata
);
    logic [REG_W-1:0] image;
    logic             unused_bits;

    assign unused_bits = ^{wdata[REG_W-1:DIV_LSB+DIV_W], wdata[DIV_LSB-1:EN_POS+1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl <= '0;
        end else if (wr) begin
            ctl.en  <= wdata[EN_POS];
            ctl.div <= wdata[DIV_LSB +: DIV_W];
        end
    end

    always_comb begin
        image                   = '0;
        image[EN_POS]           = ctl.en;
        image[STB_POS]          = stable;
        image[DIV_LSB +: DIV_W] = ctl.div;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (rd) begin
            rdata <= image;
        end
    end
endmodule

// File: rtl/sckdiv_core.sv
module sckdiv_core
    import sckdiv_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    en,
    input  div_t    div,
    input  logic    restart,
    input  logic    cpol,
    output logic    sck,
    output strobe_t stb,
    output logic    tick
);
    div_t half_len;
    div_t cnt;
    logic phase;

    assign half_len = eff_div(div);
    assign tick     = en && !restart && (cnt == div_t'(half_len - div_t'(1)));
    assign sck      = phase ^ cpol;

    always_ff @(posedge clk) begin
        if (rst || restart || !en) begin
            cnt   <= '0;
            phase <= 1'b0;
            stb   <= '0;
        end else begin
            stb <= '0;
            if (tick) begin
                cnt   <= '0;
                phase <= ~phase;
                if ((~phase) ^ cpol) stb.rise <= 1'b1;
                else                 stb.fall <= 1'b1;
            end else begin
                cnt <= cnt + div_t'(1);
            end
        end
    end
endmodule

// File: rtl/sckdiv_settle.sv
module sckdiv_settle #(
    parameter int unsigned HALVES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic tick,
    output logic stable
);
    localparam int unsigned CW = $clog2(HALVES + 1);

    logic [CW-1:0] seen;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            seen   <= '0;
            stable <= 1'b0;
        end else if (tick && (seen != CW'(HALVES))) begin
            seen <= seen + CW'(1);
            if (seen == CW'(HALVES - 1)) stable <= 1'b1;
        end
    end
endmodule

// File: rtl/sckdiv_top.sv
module sckdiv_top
    import sckdiv_pkg::*;
#(
    parameter int unsigned SETTLE_PERIODS = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             cpol,
    output logic             sck,
    output logic             sck_rise,
    output logic             sck_fall
);
    localparam int unsigned HALVES = 2 * SETTLE_PERIODS;

    ctl_t    ctl;
    logic    stable;
    logic    tick;
    strobe_t stb;

    sckdiv_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr     (reg_wr),
        .rd     (reg_rd),
        .wdata  (reg_wdata),
        .stable (stable),
        .ctl    (ctl),
        .rdata  (reg_rdata)
    );

    sckdiv_core u_core (
        .clk     (clk),
        .rst     (rst),
        .en      (ctl.en),
        .div     (ctl.div),
        .restart (reg_wr),
        .cpol    (cpol),
        .sck     (sck),
        .stb     (stb),
        .tick    (tick)
    );

    sckdiv_settle #(.HALVES(HALVES)) u_settle (
        .clk     (clk),
        .rst     (rst),
        .restart (reg_wr),
        .tick    (tick),
        .stable  (stable)
    );

    assign sck_rise = stb.rise;
    assign sck_fall = stb.fall;
endmodule

// File: rtl/sckdiv_chk.sv
module sckdiv_chk (
    input logic clk,
    input logic rst,
    input logic en,
    input logic wr,
    input logic cpol,
    input logic sck,
    input logic rise,
    input logic fall,
    input logic stable,
    input logic tick
);
    // R2
    idle_when_off_chk: assert property (@(posedge clk) disable iff (rst)
        !en |-> (sck == cpol));

    // R6
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(rise && fall));

    // R6
    rise_level_chk: assert property (@(posedge clk) disable iff (rst)
        (rise && $stable(cpol)) |-> sck);

    // R6
    fall_level_chk: assert property (@(posedge clk) disable iff (rst)
        (fall && $stable(cpol)) |-> !sck);

    // R6
    edge_has_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        (!$stable(sck) && $stable(cpol) && !$past(wr)) |-> (rise || fall));

    // R8
    write_clears_chk: assert property (@(posedge clk) disable iff (rst)
        wr |=> !stable);

    // R8
    settle_after_tick_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(stable) |-> $past(tick));
endmodule

bind sckdiv_top sckdiv_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .en     (ctl.en),
    .wr     (reg_wr),
    .cpol   (cpol),
    .sck    (sck),
    .rise   (sck_rise),
    .fall   (sck_fall),
    .stable (stable),
    .tick   (tick)
);

// File: tb/sckdiv_top_tb.sv
module sckdiv_top_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        cpol = 1'b0;
    logic        sck, sck_rise, sck_fall;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    // behavioural reference state
    int m_en = 0, m_div = 0, m_cnt = 0, m_ph = 0, m_tog = 0, m_stb = 0;
    int m_rise = 0, m_fall = 0;
    logic [31:0] m_rdata = '0;

    always #5 clk = ~clk;

    sckdiv_top u_dut (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .cpol      (cpol),
        .sck       (sck),
        .sck_rise  (sck_rise),
        .sck_fall  (sck_fall)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // reference model, one step per base edge
    always @(posedge clk) begin
        int n;
        cycles++;
        if (rst) begin
            m_en = 0; m_div = 0; m_cnt = 0; m_ph = 0; m_tog = 0; m_stb = 0;
            m_rise = 0; m_fall = 0; m_rdata = '0;
        end else begin
            if (reg_rd) m_rdata = {16'h0, m_div[7:0], 6'h0, m_stb[0], m_en[0]};
            if (reg_wr) begin
                m_en = int'(reg_wdata[0]); m_div = int'(reg_wdata[15:8]);
                m_cnt = 0; m_ph = 0; m_tog = 0; m_stb = 0; m_rise = 0; m_fall = 0;
            end else if (m_en == 0) begin
                m_cnt = 0; m_ph = 0; m_rise = 0; m_fall = 0;
            end else begin
                m_rise = 0; m_fall = 0;
                n = (m_div == 0) ? 1 : m_div;
                if (m_cnt == n - 1) begin
                    m_cnt = 0;
                    m_ph = 1 - m_ph;
                    if ((m_ph ^ int'(cpol)) == 1) m_rise = 1; else m_fall = 1;
                    if (m_tog < 4) m_tog++;
                    if (m_tog == 4) m_stb = 1;
                end else begin
                    m_cnt++;
                end
            end
        end
        #3;
        if (!rst) begin
            chk("R3 sck", {31'h0, sck}, 32'(m_ph ^ int'(cpol)));
            chk("R6 rise", {31'h0, sck_rise}, 32'(m_rise));
            chk("R6 fall", {31'h0, sck_fall}, 32'(m_fall));
            chk("R9 rdata", reg_rdata, m_rdata);
        end
    end

    always @(posedge clk) begin
        if (cycles > 150000) begin
            bad++; total++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic write(input logic [31:0] d);
        reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic read();
        reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic idle(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic until_rise(output int n);
        n = 0;
        do begin @(negedge clk); n++; end while (!sck_rise && n < 1000);
    endtask

    initial begin
        int n;
        int cnt_rise;
        logic [31:0] held;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 sck", {31'h0, sck}, 32'h0);
        chk("R1 strobes", {30'h0, sck_rise, sck_fall}, 32'h0);
        read();
        chk("R1 read", reg_rdata, 32'h0);

        // R2 disabled: no activity, idle follows cpol (R5)
        write(32'h0000_0300);
        cnt_rise = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (sck_rise || sck_fall) cnt_rise++;
        end
        chk("R2 no strobes", 32'(cnt_rise), 32'h0);
        cpol = 1'b1;
        idle(1);
        chk("R5 idle high", {31'h0, sck}, 32'h1);
        cpol = 1'b0;
        read();
        chk("R8 stays 0 when off", reg_rdata, 32'h0000_0300);

        // R3 divider 5: first rise after 5 cycles, then every 10
        write(32'h0000_0501);
        until_rise(n);
        chk("R3 first edge", 32'(n), 32'd5);
        idle(1);
        chk("R6 one-cycle rise", {31'h0, sck_rise}, 32'h0);
        until_rise(n);
        chk("R3 period", 32'(n + 1), 32'd10);

        // R8 settle: 4*N cycles after the write
        write(32'h0000_0501);
        idle(19);
        read();
        chk("R8 not yet", reg_rdata, 32'h0000_0501);
        read();
        chk("R8 set", reg_rdata, 32'h0000_0503);

        // R9 hold without read strobe
        held = reg_rdata;
        write(32'h0000_0701);
        idle(5);
        chk("R9 hold", reg_rdata, held);

        // R7 restart mid-run clears stable and returns to idle
        idle(40);
        write(32'h0000_0701);
        chk("R7 idle after write", {31'h0, sck}, 32'h0);
        read();
        chk("R7 stable cleared", reg_rdata, 32'h0000_0701);

        // R4 divider zero behaves as one
        write(32'h0000_0001);
        until_rise(n);
        chk("R4 first edge", 32'(n), 32'd1);
        until_rise(n);
        chk("R4 period", 32'(n), 32'd2);

        // R5 cpol high: first transition is a fall
        cpol = 1'b1;
        write(32'h0000_0201);
        idle(2);
        chk("R5 first fall", {31'h0, sck_fall}, 32'h1);
        chk("R5 level", {31'h0, sck}, 32'h0);
        idle(30);
        cpol = 1'b0;

        // R10 ignored bits
        write(32'hFFFF_A5FE);
        read();
        chk("R10 ignored off", reg_rdata, 32'h0000_A500);
        write(32'hFFFF_3CFF);
        read();
        chk("R10 ignored on", reg_rdata, 32'h0000_3C01);
        idle(300);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule